// File: doc/BRIEF.md
# Bus Reply Packet Checker

This block is a passive checker that sits on a 64-bit packet bus and compares reply packets with what a test environment has told it to expect. Ahead of each reply, a producer pushes an expected reply into an internal queue: a header word, a data word, and a flag that, when set, waives the data comparison for that reply. The checker never drives the bus. It only watches the grant line, the header-cycle marker and the data word.

The grant is registered once, so that the grant value in force for a bus cycle is the one seen on the cycle before. A reply is two cycles long: a header cycle, then a data cycle. The packet starts when the header marker is high while the delayed grant is set. At that point the oldest expected reply leaves the queue. The header word must match it exactly, and its command field must name one of the three legal reply kinds. In the data cycle the bus word must equal the expected data, unless the skip flag of that reply is set. Bus bits that are unknown turn the whole word into zero before any comparison.

Each kind of fault sets its own bit in a cause vector. The bits are sticky until reset, and `err` is their OR.

Top module: `reply_pkt_checker`

## Requirements
- R1: After reset, `err` is 0, `err_cause` is all zero and `exp_empty` is 1.
- R2: A packet starts only if `bus_hdr` is high in a cycle whose previous cycle had `bus_grant` high. A header with grant low in the previous cycle is ignored: no error is raised and no expected reply is consumed.
- R3: The expected queue holds `DEPTH` entries and hands them out in push order. A push while the queue is full is dropped and sets cause bit 0 (overflow), even if a pop happens in the same cycle.
- R4: A packet start while the queue is empty sets cause bit 1 (underflow), and no data check follows for that packet.
- R5: At packet start the full header word must equal the expected header; otherwise cause bit 2 is set.
- R6: The command field is header bits [63:59]. The legal values are 5'h09 (map reply), 5'h0B (I/O read reply) and 5'h0D (I/O write reply). Any other value at packet start sets cause bit 3, even when the header matches the expected header.
- R7: In the data cycle, a bus word that differs from the expected data sets cause bit 4. When the skip flag of that reply is set, no data mismatch is reported.
- R8: A header marker during the data cycle of a packet sets cause bit 5.
- R9: If the delayed grant is low during the data cycle, cause bit 6 is set. In other words, grant was dropped in the header cycle.
- R10: Cause bits are sticky until reset. `err` is the OR of the cause bits and rises on the clock edge that ends the faulty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push an expected reply this cycle |
| push_header | input | 64 | Expected header word |
| push_data | input | 64 | Expected data word |
| push_skip | input | 1 | Waive the data comparison for this reply |
| bus_grant | input | 1 | Bus grant, taken one cycle late |
| bus_hdr | input | 1 | Header-cycle marker |
| bus_data | input | 64 | Bus data word |
| exp_empty | output | 1 | Expected queue is empty |
| err | output | 1 | Sticky error, OR of `err_cause` |
| err_cause | output | 7 | Sticky per-cause error bits (bit 0..6 as in R3-R9) |

## Verification
Every fault is judged on the bus cycle in which it shows and is registered on the edge that ends that cycle. A header fault therefore appears one edge after the header cycle, and a data or grant-loss fault one edge after the data cycle. The bench drives inputs on falling edges and reads `err_cause` on the falling edge after the data cycle, so both edges have passed. `exp_empty` follows a push or a pop on the next edge, so queue state is read one half-cycle later. Grant alignment is probed by raising grant only in the header cycle and then showing that the queued entry is still there.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int unsigned RPC_W  = 64;
  localparam int unsigned NCAUSE = 7;

  localparam int unsigned C_OVF = 0;
  localparam int unsigned C_UND = 1;
  localparam int unsigned C_HDR = 2;
  localparam int unsigned C_CMD = 3;
  localparam int unsigned C_DAT = 4;
  localparam int unsigned C_HIP = 5;
  localparam int unsigned C_GLS = 6;

  typedef struct packed {
    logic [RPC_W-1:0] hdr;
    logic [RPC_W-1:0] dat;
    logic             skip;
  } rpc_exp_t;

  // A word with any unknown bit is compared as all zero.
  function automatic logic [RPC_W-1:0] rpc_scrub(input logic [RPC_W-1:0] w);
    return $isunknown(w) ? '0 : w;
  endfunction
endpackage

// File: rtl/rpc_grant_align.sv
module rpc_grant_align (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_in,
  output logic grant_d
);
  always_ff @(posedge clk) begin
    if (!rst_n) grant_d <= 1'b0;
    else        grant_d <= grant_in;
  end
endmodule

// File: rtl/rpc_exp_fifo.sv
module rpc_exp_fifo
  import rpc_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rpc_exp_t din,
  input  logic     pop,
  output rpc_exp_t head,
  output logic     empty,
  output logic     full,
  output logic     ovf_ev
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  rpc_exp_t        mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;
  logic            do_push, do_pop;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign ovf_ev  = push && full;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= next_ptr(wp);
      if (do_pop)  rp <= next_ptr(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R3: occupancy never exceeds the configured depth
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R3: a push into a full queue without a pop leaves occupancy unchanged
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/rpc_framer.sv
module rpc_framer
  import rpc_pkg::*;
#(
  parameter int unsigned CMD_W    = 5,
  parameter logic [4:0]  CODE_MAP = 5'h09,
  parameter logic [4:0]  CODE_IRD = 5'h0B,
  parameter logic [4:0]  CODE_IWR = 5'h0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_d,
  input  logic              hdr,
  input  logic [RPC_W-1:0]  data,
  input  rpc_exp_t          head,
  input  logic              q_empty,
  output logic              pop,
  output logic              pkt_start,
  output logic              in_pkt,
  output logic [NCAUSE-1:0] ev
);
  logic [RPC_W-1:0] word;
  logic [RPC_W-1:0] held_dat;
  logic             held_skip;
  logic             data_phase;

  function automatic logic [CMD_W-1:0] cmd_of(input logic [RPC_W-1:0] h);
    return h[RPC_W-1 -: CMD_W];
  endfunction

  function automatic logic cmd_legal(input logic [CMD_W-1:0] c);
    return (c == CMD_W'(CODE_MAP)) || (c == CMD_W'(CODE_IRD)) ||
           (c == CMD_W'(CODE_IWR));
  endfunction

  assign word       = rpc_scrub(data);
  assign pkt_start  = hdr && grant_d && !in_pkt;
  assign pop        = pkt_start && !q_empty;
  assign data_phase = in_pkt && !hdr;

  always_comb begin
    ev        = '0;
    ev[C_UND] = pkt_start && q_empty;
    ev[C_HDR] = pkt_start && !q_empty && (word != head.hdr);
    ev[C_CMD] = pkt_start && !cmd_legal(cmd_of(word));
    ev[C_DAT] = data_phase && !held_skip && (word != held_dat);
    ev[C_HIP] = in_pkt && hdr;
    ev[C_GLS] = in_pkt && !grant_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt    <= 1'b0;
      held_dat  <= '0;
      held_skip <= 1'b1;
    end else begin
      in_pkt <= pkt_start;
      if (pkt_start) begin
        held_dat  <= head.dat;
        held_skip <= q_empty ? 1'b1 : head.skip;
      end
    end
  end

  // R4: the queue is only popped when it holds an entry
  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !q_empty);
  // R8: every packet is exactly one header plus one data cycle
  p_two_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_pkt |=> !in_pkt);
endmodule

// File: rtl/reply_pkt_checker.sv
module reply_pkt_checker
  import rpc_pkg::*;
#(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned CMD_W    = 5,
  parameter logic [4:0]  CODE_MAP = 5'h09,
  parameter logic [4:0]  CODE_IRD = 5'h0B,
  parameter logic [4:0]  CODE_IWR = 5'h0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [63:0]       push_header,
  input  logic [63:0]       push_data,
  input  logic              push_skip,
  input  logic              bus_grant,
  input  logic              bus_hdr,
  input  logic [63:0]       bus_data,
  output logic              exp_empty,
  output logic              err,
  output logic [NCAUSE-1:0] err_cause
);
  logic              grant_d;
  rpc_exp_t          din, head;
  logic              q_empty, q_full, ovf_ev, pop, pkt_start, in_pkt;
  logic [NCAUSE-1:0] fr_ev, ev_all;

  assign din = '{hdr: push_header, dat: push_data, skip: push_skip};

  rpc_grant_align u_align (
    .clk(clk), .rst_n(rst_n), .grant_in(bus_grant), .grant_d(grant_d)
  );

  rpc_exp_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_valid), .din(din), .pop(pop),
    .head(head), .empty(q_empty), .full(q_full), .ovf_ev(ovf_ev)
  );

  rpc_framer #(
    .CMD_W(CMD_W), .CODE_MAP(CODE_MAP), .CODE_IRD(CODE_IRD), .CODE_IWR(CODE_IWR)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .grant_d(grant_d), .hdr(bus_hdr),
    .data(bus_data), .head(head), .q_empty(q_empty), .pop(pop),
    .pkt_start(pkt_start), .in_pkt(in_pkt), .ev(fr_ev)
  );

  always_comb begin
    ev_all        = fr_ev;
    ev_all[C_OVF] = ovf_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_cause <= '0;
    else        err_cause <= err_cause | ev_all;
  end

  assign err       = |err_cause;
  assign exp_empty = q_empty;

  // R2: a packet only starts when grant was high on the previous cycle
  p_start_after_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> $past(bus_grant));
  // R3: pushing into a full queue raises the overflow cause
  p_ovf_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && q_full) |=> err_cause[C_OVF]);
  // R10: the error output stays set until reset
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R10: err only rises after a detected event
  p_rise_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(|ev_all));
endmodule

// File: tb/reply_pkt_checker_tb.sv
`timescale 1ns/1ps
module reply_pkt_checker_tb_top;
  localparam int unsigned DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0, push_skip = 1'b0;
  logic [63:0] push_header = '0, push_data = '0, bus_data = '0;
  logic        bus_grant = 1'b0, bus_hdr = 1'b0;
  logic        exp_empty, err;
  logic [6:0]  err_cause;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  reply_pkt_checker #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_header(push_header),
    .push_data(push_data), .push_skip(push_skip), .bus_grant(bus_grant),
    .bus_hdr(bus_hdr), .bus_data(bus_data), .exp_empty(exp_empty),
    .err(err), .err_cause(err_cause)
  );

  function automatic logic [63:0] mk_hdr(input logic [4:0] code, input logic [63:0] low);
    return {code, low[58:0]};
  endfunction

  function automatic bit legal_code(input int c);
    return (c == 9) || (c == 11) || (c == 13);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; push_valid = 0; bus_grant = 0; bus_hdr = 0; bus_data = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [63:0] h, input logic [63:0] d, input logic s);
    @(negedge clk);
    push_valid = 1; push_header = h; push_data = d; push_skip = s;
    @(negedge clk);
    push_valid = 0;
  endtask

  // pre-cycle grant gp, header-cycle grant gh, marker in data cycle hd
  task automatic send(input logic [63:0] h, input logic [63:0] d,
                      input logic gp, input logic gh, input logic hd);
    @(negedge clk);
    bus_grant = gp; bus_hdr = 0;
    @(negedge clk);
    bus_grant = gh; bus_hdr = 1; bus_data = h;
    @(negedge clk);
    bus_grant = 1; bus_hdr = hd; bus_data = d;
    @(negedge clk);
    bus_grant = 0; bus_hdr = 0; bus_data = '0;
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] h;
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk("R1 err", {7'b0, err}, 8'h0);
    chk("R1 cause", {1'b0, err_cause}, 8'h0);
    chk("R1 empty", {7'b0, exp_empty}, 8'h1);

    // R6: sweep every command code
    for (int c = 0; c < 32; c++) begin
      do_reset();
      h = mk_hdr(5'(c), 64'h0123_4567_89AB_CDEF ^ 64'(c));
      push(h, 64'hA5A5_0000_0000_0000 + 64'(c), 1'b0);
      send(h, 64'hA5A5_0000_0000_0000 + 64'(c), 1, 1, 0);
      chk($sformatf("R6 code %0d", c), {1'b0, err_cause},
          legal_code(c) ? 8'h00 : 8'h08);
    end

    // R7: data match, mismatch, with and without skip
    for (int k = 0; k < 4; k++) begin
      bit skip = k[0];
      bit bad  = k[1];
      do_reset();
      h = mk_hdr(5'h0B, 64'h1111);
      push(h, 64'hDEAD_BEEF_0000_0042, skip);
      send(h, bad ? 64'hDEAD_BEEF_0000_0043 : 64'hDEAD_BEEF_0000_0042, 1, 1, 0);
      chk($sformatf("R7 skip=%0d bad=%0d", skip, bad), {1'b0, err_cause},
          (bad && !skip) ? 8'h10 : 8'h00);
    end

    // R5: header mismatch with legal command
    do_reset();
    push(mk_hdr(5'h09, 64'h7), 64'h5, 0);
    send(mk_hdr(5'h09, 64'h6), 64'h5, 1, 1, 0);
    chk("R5 hdr mismatch", {1'b0, err_cause}, 8'h04);

    // R2: grant only in header cycle is ignored, entry kept
    do_reset();
    h = mk_hdr(5'h0D, 64'h99);
    push(h, 64'h77, 0);
    send(h, 64'h77, 0, 1, 0);
    chk("R2 no start err", {1'b0, err_cause}, 8'h00);
    chk("R2 entry kept", {7'b0, exp_empty}, 8'h0);
    send(h, 64'h77, 1, 1, 0);
    chk("R2 later packet ok", {1'b0, err_cause}, 8'h00);
    chk("R2 entry consumed", {7'b0, exp_empty}, 8'h1);

    // R3: overflow and order; R4: underflow afterwards
    do_reset();
    for (int i = 0; i < DEPTH + 1; i++)
      push(mk_hdr(5'h09, 64'(i)), 64'(100 + i), 0);
    chk("R3 overflow flag", {1'b0, err_cause}, 8'h01);
    for (int i = 0; i < DEPTH; i++)
      send(mk_hdr(5'h09, 64'(i)), 64'(100 + i), 1, 1, 0);
    chk("R3 order preserved", {1'b0, err_cause}, 8'h01);
    chk("R3 extra dropped", {7'b0, exp_empty}, 8'h1);
    send(mk_hdr(5'h09, 64'(DEPTH)), 64'(100 + DEPTH), 1, 1, 0);
    chk("R4 underflow", {1'b0, err_cause}, 8'h03);

    // R8: header marker in data cycle
    do_reset();
    h = mk_hdr(5'h09, 64'h3);
    push(h, 64'h4, 0);
    send(h, 64'h4, 1, 1, 1);
    chk("R8 header in packet", {1'b0, err_cause}, 8'h20);

    // R9: grant dropped in header cycle
    do_reset();
    h = mk_hdr(5'h0B, 64'h5);
    push(h, 64'h6, 0);
    send(h, 64'h6, 1, 0, 0);
    chk("R9 grant lost", {1'b0, err_cause}, 8'h40);

    // R10: sticky through a clean packet, err is OR, reset clears
    h = mk_hdr(5'h0B, 64'h8);
    push(h, 64'h9, 0);
    send(h, 64'h9, 1, 1, 0);
    chk("R10 sticky", {1'b0, err_cause}, 8'h40);
    chk("R10 err", {7'b0, err}, 8'h1);
    do_reset();
    @(negedge clk);
    chk("R10 cleared", {7'b0, err}, 8'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule